// File: doc/BRIEF.md
# Serial-Addressed SRAM Access Bridge

This block lets a microcontroller with few free pins reach a byte-wide asynchronous SRAM. The host loads a 21-bit address one bit at a time. It places each bit on a serial line and then pulses an active-low shift strobe. After that it moves bytes over an 8-bit data bus, using active-low write and read requests. A small sequencer turns each request into SRAM chip-enable, output-enable and write-enable activity. Every byte passes through an internal buffer. The buffer is loaded from the source bus in one state and driven onto the destination bus in the next.

All internal logic advances on a clock enable that fires once every `CLK_DIV` input clocks, so it behaves like logic running on the host clock divided by two. The strobe, the serial bit and both requests are synchronised into that internal rate before they are used. A mode input gives the SRAM to a console-side port. In that mode the console's own address drives the SRAM, the SRAM is held in a read, and the SRAM data reaches the console output through combinational logic only. This keeps the console read inside a tight select-to-data window. Each data bus is split into a data-in, a data-out and a drive-enable, so the pads can be built outside the block.

Top module: `sram_bridge`

## Requirements
- R1: A synchronous active-high reset clears the address register to zero and puts the sequencer in idle. It leaves SRAM CE, OE and WE high (inactive) and both data drive-enables low.
- R2: The address is shifted in most significant bit first. Each completed strobe pulse (low, then high again) moves the held address left by one and puts the serial bit in bit 0. After 21 pulses the whole address appears on `sram_addr`.
- R3: The held address changes only on the internal cycle where a synchronised rising edge of the strobe is detected. Toggling the serial line alone, or holding the strobe low, leaves `sram_addr` unchanged.
- R4: The sequencer state, the address register and the input synchronisers change only on internal clock-enable cycles, which come once every `CLK_DIV` input clocks (default 2). Requests pass two synchronising stages before the sequencer acts on them.
- R5: A write request from idle first latches the host byte with CE low. In the next internal cycle it drives that byte onto the SRAM bus with WE low. While the request stays low, the sequencer alternates between these two states. The byte ends up stored at the held address.
- R6: A read request from idle first pulls SRAM CE and OE low and latches the SRAM byte. In the next internal cycle it drives that byte onto the host bus, with `host_drive` high.
- R7: Once both requests are inactive, the sequencer returns to idle. CE goes high and neither data bus is driven. The two data buses are never driven at the same time.
- R8: If the write and read requests are both low while idle, the write is served and SRAM OE stays high.
- R9: While `console_sel` is high, `console_addr` drives `sram_addr`, CE and OE are low, WE is high, and neither bridge driver is on. `console_data` equals the SRAM data input in the same cycle, with no register on the path. `console_data` is zero otherwise.
- R10: The bridge never drives the SRAM data bus while SRAM OE is low, and never has WE and OE low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-supplied clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_sdi | input | 1 | Serial address bit |
| addr_shift_n | input | 1 | Shift strobe, idles high, one bit per low pulse |
| host_we_n | input | 1 | Host write request, active low |
| host_oe_n | input | 1 | Host read request, active low |
| host_din | input | DATA_W | Byte from the host bus |
| host_dout | output | DATA_W | Byte toward the host bus |
| host_drive | output | 1 | Enables the host-side driver |
| sram_addr | output | ADDR_W | SRAM address |
| sram_din | input | DATA_W | Byte read from the SRAM bus |
| sram_dout | output | DATA_W | Byte toward the SRAM bus |
| sram_drive | output | 1 | Enables the SRAM-side driver |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| console_sel | input | 1 | Hands the SRAM to the console port |
| console_addr | input | ADDR_W | Console address |
| console_data | output | DATA_W | SRAM byte toward the console |

## Verification
The checker tests these rules on every cycle:
- No bus contention, and never two drivers at once.
- WE is low only together with CE and SRAM drive.
- Host drive only happens while the SRAM is being read.
- The address moves only on a detected strobe edge, and the state moves only on clock-enable cycles.
- The console path is combinational.
- The bridge is idle right after reset.

Other behaviours need the bench's scenarios and its cycle-level reference model:
- The order in which address bits are shifted in.
- The exact cycle each control changes.
- Stored bytes read back correctly.
- Write priority when both requests are low.
- A held-low strobe does not shift.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_TAKE_HOST = 3'd1,
      ST_PUT_SRAM  = 3'd2,
      ST_TAKE_SRAM = 3'd3,
      ST_PUT_HOST  = 3'd4
   } seq_state_t;
endpackage

// File: rtl/sbr_tick_gen.sv
module sbr_tick_gen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   generate
      if (CLK_DIV == 1) begin : g_pass
         logic unused_rst;
         assign unused_rst = rst;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(CLK_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else if (cnt == CW'(CLK_DIV - 1)) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(CLK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/sbr_addr_shifter.sv
module sbr_addr_shifter #(
   parameter int ADDR_W      = 21,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              sdi,
   input  logic              shift_n,
   output logic              shift_rise,
   output logic [ADDR_W-1:0] addr_q
);
   logic [SYNC_STAGES:0]   en_p;
   logic [SYNC_STAGES-1:0] sdi_p;

   assign shift_rise = en_p[SYNC_STAGES-1] & ~en_p[SYNC_STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         en_p   <= '1;
         sdi_p  <= '0;
         addr_q <= '0;
      end else if (tick) begin
         en_p  <= {en_p[SYNC_STAGES-1:0], shift_n};
         sdi_p <= {sdi_p[SYNC_STAGES-2:0], sdi};
         if (shift_rise) addr_q <= {addr_q[ADDR_W-2:0], sdi_p[SYNC_STAGES-1]};
      end
   end
endmodule

// File: rtl/sbr_access_seq.sv
module sbr_access_seq
   import sbr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              hold_idle,
   input  logic              we_req_n,
   input  logic              oe_req_n,
   input  logic [DATA_W-1:0] host_din,
   input  logic [DATA_W-1:0] sram_din,
   output seq_state_t        state,
   output logic [DATA_W-1:0] buf_q,
   output logic              ce_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              drive_sram,
   output logic              drive_host
);
   logic [SYNC_STAGES-1:0] we_p, oe_p;
   logic                   we_s, oe_s;
   seq_state_t             nxt;

   assign we_s = we_p[SYNC_STAGES-1];
   assign oe_s = oe_p[SYNC_STAGES-1];

   always_comb begin
      nxt = ST_IDLE;
      unique case (state)
         ST_IDLE:      nxt = !we_s ? ST_TAKE_HOST : (!oe_s ? ST_TAKE_SRAM : ST_IDLE);
         ST_TAKE_HOST: nxt = !we_s ? ST_PUT_SRAM  : ST_IDLE;
         ST_PUT_SRAM:  nxt = !we_s ? ST_TAKE_HOST : ST_IDLE;
         ST_TAKE_SRAM: nxt = !oe_s ? ST_PUT_HOST  : ST_IDLE;
         ST_PUT_HOST:  nxt = !oe_s ? ST_TAKE_SRAM : ST_IDLE;
         default:      nxt = ST_IDLE;
      endcase
      if (hold_idle) nxt = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         buf_q <= '0;
         we_p  <= '1;
         oe_p  <= '1;
      end else if (tick) begin
         we_p  <= {we_p[SYNC_STAGES-2:0], we_req_n};
         oe_p  <= {oe_p[SYNC_STAGES-2:0], oe_req_n};
         state <= nxt;
         if (state == ST_TAKE_HOST) buf_q <= host_din;
         else if (state == ST_TAKE_SRAM) buf_q <= sram_din;
      end
   end

   assign ce_n       = (state == ST_IDLE);
   assign we_n       = (state != ST_PUT_SRAM);
   assign oe_n       = !(state == ST_TAKE_SRAM || state == ST_PUT_HOST);
   assign drive_sram = (state == ST_PUT_SRAM);
   assign drive_host = (state == ST_PUT_HOST);
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
   import sbr_pkg::*;
#(
   parameter int ADDR_W      = 21,
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_sdi,
   input  logic              addr_shift_n,
   input  logic              host_we_n,
   input  logic              host_oe_n,
   input  logic [DATA_W-1:0] host_din,
   output logic [DATA_W-1:0] host_dout,
   output logic              host_drive,
   output logic [ADDR_W-1:0] sram_addr,
   input  logic [DATA_W-1:0] sram_din,
   output logic [DATA_W-1:0] sram_dout,
   output logic              sram_drive,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   input  logic              console_sel,
   input  logic [ADDR_W-1:0] console_addr,
   output logic [DATA_W-1:0] console_data
);
   generate
      if (ADDR_W < 2 || DATA_W < 1 || CLK_DIV < 1 || SYNC_STAGES < 2) begin : g_bad_cfg
         $error("sram_bridge: unsupported parameter set");
      end
   endgenerate

   logic              tick;
   logic              shift_rise;
   logic [ADDR_W-1:0] addr_q;
   seq_state_t        seq_state;
   logic [DATA_W-1:0] buf_q;
   logic              s_ce_n, s_oe_n, s_we_n, s_drv_sram, s_drv_host;

   sbr_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst(rst), .tick(tick)
   );

   sbr_addr_shifter #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_addr (
      .clk(clk), .rst(rst), .tick(tick), .sdi(addr_sdi), .shift_n(addr_shift_n),
      .shift_rise(shift_rise), .addr_q(addr_q)
   );

   sbr_access_seq #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk(clk), .rst(rst), .tick(tick), .hold_idle(console_sel),
      .we_req_n(host_we_n), .oe_req_n(host_oe_n),
      .host_din(host_din), .sram_din(sram_din),
      .state(seq_state), .buf_q(buf_q),
      .ce_n(s_ce_n), .oe_n(s_oe_n), .we_n(s_we_n),
      .drive_sram(s_drv_sram), .drive_host(s_drv_host)
   );

   assign host_dout    = buf_q;
   assign sram_dout    = buf_q;
   assign sram_addr    = console_sel ? console_addr : addr_q;
   assign sram_ce_n    = console_sel ? 1'b0 : s_ce_n;
   assign sram_oe_n    = console_sel ? 1'b0 : s_oe_n;
   assign sram_we_n    = console_sel ? 1'b1 : s_we_n;
   assign sram_drive   = console_sel ? 1'b0 : s_drv_sram;
   assign host_drive   = console_sel ? 1'b0 : s_drv_host;
   assign console_data = console_sel ? sram_din : '0;
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic              shift_rise,
   input logic [ADDR_W-1:0] addr_q,
   input seq_state_t        seq_state,
   input logic              console_sel,
   input logic [DATA_W-1:0] sram_din,
   input logic [DATA_W-1:0] console_data,
   input logic              sram_ce_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic              sram_drive,
   input logic              host_drive
);
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !console_sel) |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_drive && !host_drive));

   a_r3_addr_moves_on_edge: assert property (@(posedge clk) disable iff (rst)
      (addr_q != $past(addr_q)) |-> $past(shift_rise && tick));

   a_r4_state_on_tick: assert property (@(posedge clk) disable iff (rst)
      (seq_state != $past(seq_state)) |-> $past(tick));

   a_r5_we_with_data: assert property (@(posedge clk) disable iff (rst)
      !sram_we_n |-> (!sram_ce_n && sram_drive));

   a_r6_host_during_read: assert property (@(posedge clk) disable iff (rst)
      host_drive |-> (!sram_oe_n && !sram_ce_n));

   a_r7_one_driver: assert property (@(posedge clk) disable iff (rst)
      !(host_drive && sram_drive));

   a_r9_console_path: assert property (@(posedge clk) disable iff (rst)
      console_sel |-> (console_data == sram_din && sram_we_n && !host_drive && !sram_drive));

   a_r10_no_contention: assert property (@(posedge clk) disable iff (rst)
      !(sram_drive && !sram_oe_n) && !(!sram_we_n && !sram_oe_n));
endmodule

bind sram_bridge sram_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .shift_rise(shift_rise), .addr_q(addr_q),
   .seq_state(seq_state), .console_sel(console_sel), .sram_din(sram_din),
   .console_data(console_data), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
   .sram_we_n(sram_we_n), .sram_drive(sram_drive), .host_drive(host_drive)
);

// File: tb/sim_sram_bridge.sv
module sim_sram_bridge;
   localparam int AW  = 21;
   localparam int DW  = 8;
   localparam int DIV = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic          addr_sdi = 1'b0, addr_shift_n = 1'b1;
   logic          host_we_n = 1'b1, host_oe_n = 1'b1;
   logic [DW-1:0] host_din = '0;
   logic          console_sel = 1'b0;
   logic [AW-1:0] console_addr = '0;
   logic [DW-1:0] host_dout, sram_dout, sram_din, console_data;
   logic [AW-1:0] sram_addr;
   logic          host_drive, sram_drive, sram_ce_n, sram_oe_n, sram_we_n;

   logic [7:0] mem [0:1023];
   assign sram_din = (!sram_oe_n && !sram_ce_n) ? mem[sram_addr[9:0]] : 8'h00;

   sram_bridge u0 (
      .clk(clk), .rst(rst), .addr_sdi(addr_sdi), .addr_shift_n(addr_shift_n),
      .host_we_n(host_we_n), .host_oe_n(host_oe_n), .host_din(host_din),
      .host_dout(host_dout), .host_drive(host_drive), .sram_addr(sram_addr),
      .sram_din(sram_din), .sram_dout(sram_dout), .sram_drive(sram_drive),
      .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .console_sel(console_sel), .console_addr(console_addr), .console_data(console_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // Behavioural reference model, advanced at every rising clock
   int            m_cnt, m_state, m_nxt;
   bit            m_tick;
   logic [AW-1:0] m_addr;
   logic [7:0]    m_buf;
   logic [2:0]    m_en;
   logic [1:0]    m_sdi, m_we, m_oe;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_state = 0; m_addr = '0; m_buf = '0;
         m_en = 3'b111; m_sdi = 2'b00; m_we = 2'b11; m_oe = 2'b11;
      end else begin
         m_tick = (m_cnt == DIV - 1);
         m_cnt  = m_tick ? 0 : m_cnt + 1;
         if (m_tick) begin
            case (m_state)
               0: m_nxt = !m_we[1] ? 1 : (!m_oe[1] ? 3 : 0);
               1: m_nxt = !m_we[1] ? 2 : 0;
               2: m_nxt = !m_we[1] ? 1 : 0;
               3: m_nxt = !m_oe[1] ? 4 : 0;
               4: m_nxt = !m_oe[1] ? 3 : 0;
               default: m_nxt = 0;
            endcase
            if (console_sel) m_nxt = 0;
            if (m_state == 1) m_buf = host_din;
            if (m_state == 3) m_buf = sram_din;
            if (m_en[1] && !m_en[2]) m_addr = {m_addr[AW-2:0], m_sdi[1]};
            m_en  = {m_en[1:0], addr_shift_n};
            m_sdi = {m_sdi[0], addr_sdi};
            m_we  = {m_we[0], host_we_n};
            m_oe  = {m_oe[0], host_oe_n};
            m_state = m_nxt;
         end
      end
   end

   logic [7:0] last_rd;
   bit         saw_we, saw_oe;

   always @(negedge clk) begin
      if (!rst) begin
         if (console_sel) begin
            check(sram_addr == console_addr, "R9 addr", sram_addr, console_addr);
            check(!sram_ce_n && !sram_oe_n && sram_we_n, "R9 ctl",
                  {sram_ce_n, sram_oe_n, sram_we_n}, 3'b001);
            check(!sram_drive && !host_drive, "R9 drv", {sram_drive, host_drive}, 2'b00);
            check(console_data == mem[console_addr[9:0]], "R9 data", console_data, mem[console_addr[9:0]]);
         end else begin
            check(sram_addr == m_addr, "R2 addr", sram_addr, m_addr);
            check(sram_ce_n == (m_state == 0), "R4 ce_n", sram_ce_n, m_state == 0);
            check(sram_we_n == (m_state != 2), "R5 we_n", sram_we_n, m_state != 2);
            check(sram_drive == (m_state == 2), "R5 sram_drive", sram_drive, m_state == 2);
            check(sram_oe_n == !(m_state == 3 || m_state == 4), "R6 oe_n", sram_oe_n, !(m_state == 3 || m_state == 4));
            check(host_drive == (m_state == 4), "R6 host_drive", host_drive, m_state == 4);
            check(console_data == '0, "R9 idle data", console_data, 0);
            if (sram_drive) check(sram_dout == m_buf, "R5 sram_dout", sram_dout, m_buf);
            if (host_drive) check(host_dout == m_buf, "R6 host_dout", host_dout, m_buf);
         end
         check(!(sram_drive && !sram_oe_n), "R10 contention", {sram_drive, sram_oe_n}, 2'b01);
         if (host_drive) last_rd = host_dout;
         if (!sram_we_n) saw_we = 1'b1;
         if (!sram_oe_n) saw_oe = 1'b1;
         if (!sram_we_n && !sram_ce_n && sram_drive) mem[sram_addr[9:0]] = sram_dout;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic shift_addr(input logic [AW-1:0] a);
      for (int i = AW - 1; i >= 0; i--) begin
         addr_sdi = a[i];
         step(3);
         addr_shift_n = 1'b0;
         step(6);
         addr_shift_n = 1'b1;
         step(4);
      end
      step(8);
   endtask

   task automatic do_write(input logic [7:0] d);
      host_we_n = 1'b1; host_oe_n = 1'b1;
      step(6);
      host_din = d;
      host_we_n = 1'b0;
      step(12);
      host_we_n = 1'b1;
      step(10);
   endtask

   task automatic do_read();
      last_rd = 8'hxx;
      host_oe_n = 1'b0;
      step(12);
      host_oe_n = 1'b1;
      step(10);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [AW-1:0] a1, a2, held;
      for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
      step(4);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(sram_addr == '0, "R1 addr", sram_addr, 0);
      check(sram_ce_n && sram_oe_n && sram_we_n, "R1 ctl", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
      check(!host_drive && !sram_drive, "R1 drv", {host_drive, sram_drive}, 2'b00);

      // R2: MSB-first shifting of two addresses
      a1 = 21'h1A_B3C5;
      shift_addr(a1);
      @(negedge clk);
      check(sram_addr == a1, "R2 full address", sram_addr, a1);
      a2 = 21'h00_0123;
      shift_addr(a2);
      @(negedge clk);
      check(sram_addr == a2, "R2 second address", sram_addr, a2);

      // R3: serial line toggling and a held-low strobe do not shift
      for (int i = 0; i < 10; i++) begin addr_sdi = ~addr_sdi; step(2); end
      @(negedge clk);
      check(sram_addr == a2, "R3 sdi toggle", sram_addr, a2);
      addr_sdi = 1'b1;
      step(2);
      addr_shift_n = 1'b0;
      step(20);
      @(negedge clk);
      check(sram_addr == a2, "R3 strobe held low", sram_addr, a2);
      step(1);
      addr_shift_n = 1'b1;
      step(8);
      @(negedge clk);
      held = {a2[AW-2:0], 1'b1};
      check(sram_addr == held, "R3 shift on release", sram_addr, held);
      shift_addr(a2);

      // R5 / R6: write then read back at a2
      do_write(8'hA7);
      check(mem[a2[9:0]] == 8'hA7, "R5 stored byte", mem[a2[9:0]], 8'hA7);
      do_read();
      check(last_rd == 8'hA7, "R6 read back", last_rd, 8'hA7);

      // R7: idle after requests released
      @(negedge clk);
      check(sram_ce_n && !host_drive && !sram_drive, "R7 idle", {sram_ce_n, host_drive, sram_drive}, 3'b100);

      // R5 / R6 at a1 with another byte
      shift_addr(a1);
      do_write(8'h3C);
      check(mem[a1[9:0]] == 8'h3C, "R5 stored byte 2", mem[a1[9:0]], 8'h3C);
      do_read();
      check(last_rd == 8'h3C, "R6 read back 2", last_rd, 8'h3C);

      // R8: both requests low together, write wins
      saw_we = 1'b0; saw_oe = 1'b0;
      host_din = 8'h5E;
      host_we_n = 1'b0; host_oe_n = 1'b0;
      step(12);
      host_we_n = 1'b1; host_oe_n = 1'b1;
      step(10);
      check(saw_we, "R8 write served", saw_we, 1);
      check(!saw_oe, "R8 no read", saw_oe, 0);
      check(mem[a1[9:0]] == 8'h5E, "R8 stored byte", mem[a1[9:0]], 8'h5E);

      // R9: console mode reads through combinationally
      console_addr = a2;
      console_sel = 1'b1;
      @(negedge clk);
      check(console_data == 8'hA7, "R9 console byte", console_data, 8'hA7);
      step(1);
      console_addr = a1;
      @(negedge clk);
      check(console_data == 8'h5E, "R9 console byte 2", console_data, 8'h5E);
      check(sram_addr == a1, "R9 console address", sram_addr, a1);
      step(2);
      console_sel = 1'b0;
      step(4);
      @(negedge clk);
      check(sram_addr == a1 && sram_ce_n, "R9 release", {sram_ce_n, sram_addr}, {1'b1, a1});

      finish_run();
   end
endmodule